// File: doc/BRIEF.md
# Dataflow Channel Communication Assist

This block stands between a processing element and its local data memory and looks after one outgoing streaming channel that follows synchronous-dataflow firing rules. The channel occupies a circular region of the processor's own data memory, so tokens are produced in place with no copy buffer. The block tells the processor when its actor may fire, reserves the output space for the whole firing, lets the processor touch the reserved window in any order, and makes the tokens visible only when the firing is committed.

Committed tokens are read back from memory, one word at a time, and pushed into a point-to-point network FIFO, holding a word whenever the FIFO reports full. The remote consumer returns a release pulse once it has finished a firing, which frees one consumption-rate worth of places. Base, size and both rates are loaded through a small write port while the channel is disabled; the region size need not be a power of two.

Top module: `dfchan_assist`

## Requirements
- R1: `fire_ready` is high exactly when the channel is enabled, no firing is open, and the free place count is at least the production rate.
- R2: A `fire_start` pulse while `fire_ready` is high opens a firing: on the next cycle `free_cnt` has dropped by the production rate and `fire_ready` is low until commit; a `fire_start` while not ready is ignored.
- R3: A `fire_done` pulse while a firing is open closes it, advances the write pointer by the production rate modulo the size, and raises `fill_cnt` by the production rate on the next cycle.
- R4: While a firing is open, an access with `pe_idx` below the production rate drives the memory port at `base + ((wptr + pe_idx) mod size)` in the same cycle; reads may come in any order and repeat, and the word appears on `pe_rdata` with `pe_rvalid` high one cycle later.
- R5: An access with `pe_idx` at or above the production rate, or with no open firing, makes no memory request and raises `pe_err` for one cycle on the next cycle.
- R6: Only committed tokens are sent to the FIFO, in slot order, one word per `fifo_push`; `fifo_push` is never high while `fifo_full` is high, and a held word waits without loss.
- R7: A `credit_rel` pulse lowers `fill_cnt` by the consumption rate and frees those places, but only when at least that many committed tokens have already been sent; otherwise it is ignored.
- R8: Configuration writes use `cfg_sel` 0 = base, 1 = size, 2 = consumption rate, 3 = production rate and take effect only while `ch_en` is low; writes while enabled are ignored, and a disabled channel clears its pointers, counts and open firing.
- R9: Pointers wrap modulo a size that need not be a power of two, so a window that runs past the end of the region continues at the base address.
- R10: A processor access owns the memory port in its cycle; the transfer engine reads memory only in cycles without a processor request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | 1 | Channel enable; low clears the channel state |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration field select |
| cfg_wdata | input | AW | Configuration write value |
| fire_start | input | 1 | Open a firing |
| fire_done | input | 1 | Commit the open firing |
| fire_ready | output | 1 | Actor may fire |
| free_cnt | output | CW | Free places, reservation excluded |
| fill_cnt | output | CW | Committed, unreleased tokens |
| pe_req | input | 1 | Processor window access |
| pe_we | input | 1 | Processor write when high |
| pe_idx | input | CW | Token index inside the window |
| pe_wdata | input | DW | Processor write data |
| pe_rdata | output | DW | Processor read data |
| pe_rvalid | output | 1 | `pe_rdata` is valid |
| pe_err | output | 1 | Rejected out-of-window access |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after request |
| fifo_full | input | 1 | Network FIFO cannot accept |
| fifo_push | output | 1 | Word pushed to network FIFO |
| fifo_data | output | DW | Pushed word |
| credit_rel | input | 1 | Release from the remote consumer |

## Verification
The bench builds the block with a 10-bit address, 8-bit counts and 16-bit words, and loads a region of 10 places at base 100 with a production rate of 4 and a consumption rate of 6. Because 10 is not a multiple of 4 nor a power of two, the third firing straddles the end of the region and the release leaves a partial remainder, bringing the modulo wrap, the not-ready case at two free places and the refused early release within reach in a few dozen cycles. Holding the FIFO full across a commit exposes the stall path, and opening a second firing while words of the first are still queued exercises memory-port priority.

// File: rtl/dfchan_pkg.sv
package dfchan_pkg;

    typedef enum logic [1:0] {
        FLD_BASE = 2'd0,
        FLD_SIZE = 2'd1,
        FLD_CONS = 2'd2,
        FLD_PROD = 2'd3
    } cfg_fld_e;

endpackage

// File: rtl/dfchan_wrap_add.sv
// Modular add: s = (a + b) mod m, valid for a < m and b <= m.
module dfchan_wrap_add #(
    parameter int CW = 10
) (
    input  logic [CW-1:0] a,
    input  logic [CW-1:0] b,
    input  logic [CW-1:0] m,
    output logic [CW-1:0] s
);
    logic [CW:0] sum;
    logic [CW:0] red;

    always_comb begin
        sum = {1'b0, a} + {1'b0, b};
        red = sum - {1'b0, m};
        s   = (sum >= {1'b0, m}) ? red[CW-1:0] : sum[CW-1:0];
    end
endmodule

// File: rtl/dfchan_drain.sv
// Moves committed tokens from the region to the network FIFO.
module dfchan_drain #(
    parameter int AW = 12,
    parameter int CW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] size,
    input  logic          add_en,
    input  logic [CW-1:0] add_cnt,
    input  logic          mem_free,
    input  logic [DW-1:0] mem_rdata,
    input  logic          fifo_full,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    output logic          fifo_push,
    output logic [DW-1:0] fifo_data,
    output logic [CW-1:0] unsent
);
    typedef struct packed {
        logic [CW-1:0] sptr;
        logic [CW-1:0] unsent;
        logic          pend;
        logic          hold;
        logic [DW-1:0] data;
    } drain_t;

    drain_t        s_d, s_q;
    logic [CW-1:0] sptr_inc;

    dfchan_wrap_add #(.CW(CW)) u_inc (
        .a(s_q.sptr), .b(CW'(1)), .m(size), .s(sptr_inc)
    );

    always_comb begin
        s_d       = s_q;
        fifo_push = s_q.hold & ~fifo_full;
        rd_req    = ~clr & mem_free & (s_q.unsent != '0) & ~s_q.pend
                    & (~s_q.hold | fifo_push);
        if (rd_req) begin
            s_d.sptr = sptr_inc;
        end
        s_d.unsent = s_q.unsent + (add_en ? add_cnt : '0) - (rd_req ? CW'(1) : '0);
        s_d.pend   = rd_req;
        if (s_q.pend) begin
            s_d.hold = 1'b1;
            s_d.data = mem_rdata;
        end else if (fifo_push) begin
            s_d.hold = 1'b0;
        end
        if (clr) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_addr   = base + AW'(s_q.sptr);
    assign fifo_data = s_q.data;
    assign unsent    = s_q.unsent;
endmodule

// File: rtl/dfchan_assist.sv
module dfchan_assist #(
    parameter int AW = 12,
    parameter int CW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ch_en,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          fire_start,
    input  logic          fire_done,
    output logic          fire_ready,
    output logic [CW-1:0] free_cnt,
    output logic [CW-1:0] fill_cnt,
    input  logic          pe_req,
    input  logic          pe_we,
    input  logic [CW-1:0] pe_idx,
    input  logic [DW-1:0] pe_wdata,
    output logic [DW-1:0] pe_rdata,
    output logic          pe_rvalid,
    output logic          pe_err,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          fifo_full,
    output logic          fifo_push,
    output logic [DW-1:0] fifo_data,
    input  logic          credit_rel
);
    import dfchan_pkg::*;

    typedef struct packed {
        logic [AW-1:0] base;
        logic [CW-1:0] size;
        logic [CW-1:0] cons;
        logic [CW-1:0] prod;
        logic [CW-1:0] wptr;
        logic [CW-1:0] rptr;
        logic [CW-1:0] occ;
        logic          open;
        logic          err;
        logic          rvld;
    } chan_t;

    chan_t         c_d, c_q;
    logic [CW-1:0] win_slot;
    logic [CW-1:0] wptr_adv;
    logic [CW-1:0] rptr_adv;
    logic [CW-1:0] unsent;
    logic [CW-1:0] room;
    logic [CW-1:0] sent_held;
    logic          win_ok;
    logic          pe_hit;
    logic          commit;
    logic          release_ok;
    logic          dr_req;
    logic [AW-1:0] dr_addr;

    // Names the checker reaches through bind.
    logic [CW-1:0] cfg_prod, cfg_size, wr_ptr, rd_ptr, occ_cnt;
    assign cfg_prod = c_q.prod;
    assign cfg_size = c_q.size;
    assign wr_ptr   = c_q.wptr;
    assign rd_ptr   = c_q.rptr;
    assign occ_cnt  = c_q.occ;

    dfchan_wrap_add #(.CW(CW)) u_win (
        .a(c_q.wptr), .b(pe_idx), .m(c_q.size), .s(win_slot)
    );
    dfchan_wrap_add #(.CW(CW)) u_wadv (
        .a(c_q.wptr), .b(c_q.prod), .m(c_q.size), .s(wptr_adv)
    );
    dfchan_wrap_add #(.CW(CW)) u_radv (
        .a(c_q.rptr), .b(c_q.cons), .m(c_q.size), .s(rptr_adv)
    );

    dfchan_drain #(.AW(AW), .CW(CW), .DW(DW)) u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (~ch_en),
        .base      (c_q.base),
        .size      (c_q.size),
        .add_en    (commit),
        .add_cnt   (c_q.prod),
        .mem_free  (~pe_req),
        .mem_rdata (mem_rdata),
        .fifo_full (fifo_full),
        .rd_req    (dr_req),
        .rd_addr   (dr_addr),
        .fifo_push (fifo_push),
        .fifo_data (fifo_data),
        .unsent    (unsent)
    );

    always_comb begin
        c_d        = c_q;
        room       = c_q.size - c_q.occ;
        sent_held  = c_q.occ - unsent;
        fire_ready = ch_en & ~c_q.open & (room >= c_q.prod);
        commit     = ch_en & c_q.open & fire_done;
        release_ok = ch_en & credit_rel & (sent_held >= c_q.cons);
        win_ok     = ch_en & c_q.open & (pe_idx < c_q.prod);
        pe_hit     = pe_req & win_ok;

        if (fire_start && fire_ready) begin
            c_d.open = 1'b1;
        end
        if (commit) begin
            c_d.open = 1'b0;
            c_d.wptr = wptr_adv;
        end
        if (release_ok) begin
            c_d.rptr = rptr_adv;
        end
        c_d.occ  = c_q.occ + (commit ? c_q.prod : '0) - (release_ok ? c_q.cons : '0);
        c_d.err  = pe_req & ~win_ok;
        c_d.rvld = pe_hit & ~pe_we;

        if (!ch_en) begin
            c_d.wptr = '0;
            c_d.rptr = '0;
            c_d.occ  = '0;
            c_d.open = 1'b0;
            if (cfg_we) begin
                case (cfg_fld_e'(cfg_sel))
                    FLD_BASE: c_d.base = cfg_wdata;
                    FLD_SIZE: c_d.size = cfg_wdata[CW-1:0];
                    FLD_CONS: c_d.cons = cfg_wdata[CW-1:0];
                    FLD_PROD: c_d.prod = cfg_wdata[CW-1:0];
                    default:  c_d.base = c_q.base;
                endcase
            end
        end

        mem_req   = pe_hit | dr_req;
        mem_we    = pe_hit & pe_we;
        mem_addr  = pe_hit ? (c_q.base + AW'(win_slot)) : dr_addr;
        mem_wdata = pe_wdata;
        free_cnt  = room - (c_q.open ? c_q.prod : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign fill_cnt  = c_q.occ;
    assign pe_rdata  = mem_rdata;
    assign pe_rvalid = c_q.rvld;
    assign pe_err    = c_q.err;
endmodule

// File: rtl/dfchan_assist_chk.sv
module dfchan_assist_chk #(
    parameter int CW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ch_en,
    input logic          fire_start,
    input logic          fire_ready,
    input logic [CW-1:0] free_cnt,
    input logic [CW-1:0] fill_cnt,
    input logic          fifo_push,
    input logic          fifo_full,
    input logic          pe_err,
    input logic          mem_req,
    input logic [CW-1:0] cfg_prod,
    input logic [CW-1:0] cfg_size,
    input logic [CW-1:0] wr_ptr,
    input logic [CW-1:0] rd_ptr,
    input logic [CW-1:0] occ_cnt
);
    logic [CW:0]   ring_sum;
    logic [CW-1:0] ring_pos;

    always_comb begin
        ring_sum = {1'b0, rd_ptr} + {1'b0, occ_cnt};
        ring_pos = (ring_sum >= {1'b0, cfg_size}) ? CW'(ring_sum - {1'b0, cfg_size})
                                                  : ring_sum[CW-1:0];
    end

    AST_READY_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        fire_ready |-> (free_cnt >= cfg_prod)); // R1
    AST_START_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_start && fire_ready) |=> !fire_ready); // R2
    AST_ERR_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        pe_err |-> !$past(mem_req)); // R5
    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !fifo_full); // R6
    AST_PUSH_COMMITTED: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> (fill_cnt != '0)); // R6
    AST_SPACE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ch_en |-> ({1'b0, fill_cnt} + {1'b0, free_cnt} <= {1'b0, cfg_size})); // R7
    AST_RING_CONSIST: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en && cfg_size != '0) |-> (ring_pos == wr_ptr)); // R9
endmodule

bind dfchan_assist dfchan_assist_chk #(.CW(CW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ch_en      (ch_en),
    .fire_start (fire_start),
    .fire_ready (fire_ready),
    .free_cnt   (free_cnt),
    .fill_cnt   (fill_cnt),
    .fifo_push  (fifo_push),
    .fifo_full  (fifo_full),
    .pe_err     (pe_err),
    .mem_req    (mem_req),
    .cfg_prod   (cfg_prod),
    .cfg_size   (cfg_size),
    .wr_ptr     (wr_ptr),
    .rd_ptr     (rd_ptr),
    .occ_cnt    (occ_cnt)
);

// File: tb/dfchan_assist_tb_top.sv
`timescale 1ns/1ps
module dfchan_assist_tb_top;
    localparam int AW = 10;
    localparam int CW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ch_en = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          fire_start = 1'b0;
    logic          fire_done = 1'b0;
    logic          fire_ready;
    logic [CW-1:0] free_cnt;
    logic [CW-1:0] fill_cnt;
    logic          pe_req = 1'b0;
    logic          pe_we = 1'b0;
    logic [CW-1:0] pe_idx = '0;
    logic [DW-1:0] pe_wdata = '0;
    logic [DW-1:0] pe_rdata;
    logic          pe_rvalid;
    logic          pe_err;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          fifo_full = 1'b0;
    logic          fifo_push;
    logic [DW-1:0] fifo_data;
    logic          credit_rel = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    logic [DW-1:0] exp_q[$];

    always #10 clk = ~clk;

    dfchan_assist #(.AW(AW), .CW(CW), .DW(DW)) dut_i (.*);

    // Bench-side data memory, one cycle read latency.
    logic [DW-1:0] ram [1 << AW];
    logic [DW-1:0] ram_q = '0;
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else        ram_q <= ram[mem_addr];
        end
    end
    assign mem_rdata = ram_q;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic cfg_write(logic [1:0] sel, logic [AW-1:0] val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_start();
        fire_start = 1'b1; tick(); fire_start = 1'b0;
    endtask

    task automatic pulse_release();
        credit_rel = 1'b1; tick(); credit_rel = 1'b0;
    endtask

    // Driver: commit and push the window contents in token order.
    task automatic commit_window(logic [DW-1:0] first);
        for (int i = 0; i < 4; i++) exp_q.push_back(first + DW'(i));
        fire_done = 1'b1; tick(); fire_done = 1'b0;
    endtask

    task automatic pe_write(int idx, logic [DW-1:0] val, logic [AW-1:0] exp_addr, string req);
        pe_req = 1'b1; pe_we = 1'b1; pe_idx = CW'(idx); pe_wdata = val;
        @(negedge clk);
        check(req, {mem_req, mem_we}, 2'b11);
        check(req, mem_addr, exp_addr);
        tick();
        pe_req = 1'b0; pe_we = 1'b0;
    endtask

    task automatic pe_read(int idx, logic [DW-1:0] exp);
        pe_req = 1'b1; pe_we = 1'b0; pe_idx = CW'(idx);
        tick();
        pe_req = 1'b0;
        @(negedge clk);
        check("R4 rvalid", pe_rvalid, 1'b1);
        check("R4 rdata", pe_rdata, exp);
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 80 && exp_q.size() != 0; i++) tick();
        check("R6 all words sent", exp_q.size(), 0);
    endtask

    // Monitor: compare every pushed word against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && fifo_push) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R6 unexpected push: actual %0h expected none", fifo_data);
            end else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                if (fifo_data !== e) begin
                    n_fail++;
                    $display("FAIL R6 fifo word: actual %0h expected %0h", fifo_data, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int order[4] = '{3, 1, 0, 2};
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset ready", fire_ready, 1'b0);
        check("R8 reset fill", fill_cnt, 0);
        check("R8 reset free", free_cnt, 0);
        check("R10 reset mem_req", mem_req, 1'b0);
        check("R5 reset err", pe_err, 1'b0);

        tick();
        cfg_write(2'd0, 10'd100);
        cfg_write(2'd1, 10'd10);
        cfg_write(2'd2, 10'd6);
        cfg_write(2'd3, 10'd4);
        ch_en = 1'b1;
        tick();
        @(negedge clk);
        check("R1 ready after enable", fire_ready, 1'b1);
        check("R8 free after enable", free_cnt, 10);

        tick();
        cfg_write(2'd1, 10'd3);
        @(negedge clk);
        check("R8 config ignored while enabled", free_cnt, 10);

        // Firing 1 with the FIFO blocked.
        fifo_full = 1'b1;
        tick();
        pulse_start();
        @(negedge clk);
        check("R2 ready drops", fire_ready, 1'b0);
        check("R2 space reserved", free_cnt, 6);
        tick();
        pulse_start();
        @(negedge clk);
        check("R2 start ignored while open", free_cnt, 6);
        tick();
        foreach (order[k]) pe_write(order[k], DW'(16'hA000 + order[k]),
                                    AW'(100 + order[k]), "R4 window write");
        pe_read(1, 16'hA001);
        tick();
        pe_read(1, 16'hA001);
        tick();
        pe_read(3, 16'hA003);
        tick();
        pe_req = 1'b1; pe_we = 1'b1; pe_idx = 8'd4; pe_wdata = 16'hDEAD;
        @(negedge clk);
        check("R5 no mem request", mem_req, 1'b0);
        tick();
        pe_req = 1'b0; pe_we = 1'b0;
        @(negedge clk);
        check("R5 error flag", pe_err, 1'b1);
        fifo_full = 1'b0;
        for (int i = 0; i < 5; i++) begin
            tick();
            @(negedge clk);
            check("R6 nothing before commit", fifo_push, 1'b0);
        end
        tick();
        fifo_full = 1'b1;
        commit_window(16'hA000);
        @(negedge clk);
        check("R3 fill after commit", fill_cnt, 4);
        check("R3 free after commit", free_cnt, 6);
        check("R1 ready again", fire_ready, 1'b1);
        for (int i = 0; i < 6; i++) begin
            tick();
            @(negedge clk);
            check("R6 stall while full", fifo_push, 1'b0);
        end
        tick();
        pulse_release();
        @(negedge clk);
        check("R7 early release ignored", fill_cnt, 4);

        // Firing 2 while words of firing 1 are still queued.
        tick();
        fifo_full = 1'b0;
        pulse_start();
        for (int i = 0; i < 4; i++) pe_write(i, DW'(16'hB000 + i), AW'(104 + i), "R10 pe owns port");
        commit_window(16'hB000);
        @(negedge clk);
        check("R3 fill second commit", fill_cnt, 8);
        check("R1 free two", free_cnt, 2);
        check("R1 not ready at two free", fire_ready, 1'b0);
        wait_drain();
        pulse_release();
        @(negedge clk);
        check("R7 fill after release", fill_cnt, 2);
        check("R7 free after release", free_cnt, 8);

        // Firing 3 wraps past the end of the region.
        tick();
        pulse_start();
        pe_write(0, 16'hC000, 10'd108, "R9 slot 8");
        pe_write(1, 16'hC001, 10'd109, "R9 slot 9");
        pe_write(2, 16'hC002, 10'd100, "R9 wrap slot 0");
        pe_write(3, 16'hC003, 10'd101, "R9 wrap slot 1");
        pe_read(2, 16'hC002);
        tick();
        commit_window(16'hC000);
        @(negedge clk);
        check("R3 fill third commit", fill_cnt, 6);
        wait_drain();
        pulse_release();
        @(negedge clk);
        check("R7 drained fill", fill_cnt, 0);
        check("R7 drained free", free_cnt, 10);

        // Disable clears state; starts and accesses are then refused.
        tick();
        pulse_start();
        ch_en = 1'b0;
        tick();
        @(negedge clk);
        check("R8 disable clears fill", fill_cnt, 0);
        check("R1 not ready when disabled", fire_ready, 1'b0);
        pulse_start();
        pe_req = 1'b1; pe_we = 1'b0; pe_idx = 8'd0;
        @(negedge clk);
        check("R5 no window when disabled", mem_req, 1'b0);
        tick();
        pe_req = 1'b0;
        @(negedge clk);
        check("R5 error when disabled", pe_err, 1'b1);

        repeat (4) tick();
        check("R6 scoreboard empty", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule